// File: doc/BRIEF.md
# Two-Wire Slave with Write-Enable Gating

This block is a serial slave on a two-wire bus (clock line plus open-drain data line). It gives a master access to a 256-location register and memory space. The block oversamples both bus lines with the system clock and recognises START and STOP conditions. It checks an address byte against a fixed device type and three strap pins, and moves bytes most significant bit first. To acknowledge a byte it enables a pull-down on the data line during the ninth clock.

After a write-addressed device byte, the first data byte sets an internal word pointer. Each later byte is written through a simple memory port, and the pointer advances after every accepted byte. An external write-enable latch decides whether a byte may be written. One register is exempt from that rule. Three registers lock out any further data byte in the same transfer. The reserved block 88h to 8Fh is never written. A refused byte gets no acknowledge, and the slave then ignores the bus until the next START. In a read transfer the slave sends bytes starting at the pointer. It continues while the master acknowledges and stops at the first not-acknowledge.

Top module: `twi_wel_slave`

## Requirements
- R1: A START from any state begins a new device-address phase. A STOP returns the slave to idle with the data pull-down released. A START in the middle of a byte abandons that byte.
- R2: After reset the pull-down is off. Clocked bytes that do not follow a START get no acknowledge and cause no write.
- R3: The device byte matches when bits 7..4 are 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 is 1 for read and 0 for write. A matching byte is acknowledged by holding SDA low through the ninth SCL high phase. A non-matching byte is not acknowledged, and the slave goes idle.
- R4: Bytes are received MSB first. In a write transfer the first byte after the device byte is loaded into the word pointer and is always acknowledged.
- R5: With wel_i = 1, a data byte to an allowed address is acknowledged and written with one mem_we_o pulse at mem_addr_o = pointer. The pointer then increments by one.
- R6: With wel_i = 0, a data byte is neither acknowledged nor written. The exception is a byte whose pointer is 86h; that byte is accepted.
- R7: Once a data byte has been accepted at pointer 80h, 85h or 86h, the next data byte in the same transfer is refused.
- R8: A data byte aimed at pointer 88h..8Fh is refused whatever the value of wel_i.
- R9: In a read transfer the slave sends the byte at the pointer MSB first, and the pointer increments after each byte. A master acknowledge (SDA low on the ninth clock) starts the next byte. A not-acknowledge releases SDA and sends the slave idle.
- R10: After a refused data byte the slave acknowledges nothing more until the next START.
- R11: A repeated START after a pointer write keeps the pointer, so a read-addressed device byte that follows reads from that pointer.
- R12: The pull-down output changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Enables the open-drain pull-down on the data line |
| strap_i | input | 3 | Device address strap pins |
| wel_i | input | 1 | Write-enable latch state |
| mem_addr_o | output | 8 | Word pointer presented to the memory |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | One-cycle read strobe; mem_rdata_i is sampled in the same cycle |
| mem_rdata_i | input | 8 | Read data for mem_addr_o, combinational |

## Verification
The assertions check on every cycle that:
- no write strobe ever escapes the write-enable gate or lands in the reserved block;
- nothing is written while the lock-out flag from 80h/85h/86h is set;
- a START always rearms the address phase with the bus released;
- the pull-down changes only while SCL is low.

Some behaviour only the bench scenarios can show: which bytes actually receive an acknowledge, memory contents after accepted and refused bytes, pointer auto-increment across write and read bursts, the repeated-START random read, and the ignore-until-START behaviour after a refusal or an aborted byte.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int ACK_SLOT = 8;   // count value after eighth data rise
    localparam int END_SLOT = 9;   // count value after the ninth rise

    localparam logic [3:0]        DEV_TYPE    = 4'b1010;
    localparam logic [BYTE_W-1:0] EXEMPT_ADDR = 8'h86;
    localparam logic [4:0]        RSVD_HI     = 5'b10001;  // 88h..8Fh

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_PTR,
        PH_WR,
        PH_RD
    } phase_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [2:0]        strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

    function automatic logic is_lock_addr(input logic [BYTE_W-1:0] a);
        return (a == 8'h80) || (a == 8'h85) || (a == 8'h86);
    endfunction

    function automatic logic is_rsvd(input logic [BYTE_W-1:0] a);
        return a[7:3] == RSVD_HI;
    endfunction

endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync[0] <= scl_i;
            sda_sync[0] <= sda_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_sync[i] <= scl_sync[i-1];
                sda_sync[i] <= sda_sync[i-1];
            end
            scl_q <= scl_sync[LAST];
            sda_q <= sda_sync[LAST];
        end
    end

    assign scl_lvl   = scl_sync[LAST];
    assign sda_lvl   = sda_sync[LAST];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/twi_wr_policy.sv
module twi_wr_policy
    import twi_pkg::*;
(
    input  logic [BYTE_W-1:0] ptr,
    input  logic              wel,
    input  logic              locked,
    output logic              accept,
    output logic              lock_next
);
    logic enabled;

    always_comb begin
        enabled   = wel || (ptr == EXEMPT_ADDR);
        accept    = enabled && !locked && !is_rsvd(ptr);
        lock_next = is_lock_addr(ptr);
    end

endmodule

// File: rtl/twi_wel_slave.sv
module twi_wel_slave
    import twi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [2:0]        strap_i,
    input  logic              wel_i,
    output logic [BYTE_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txbuf;
    logic [BYTE_W-1:0] ptr;
    logic              rd_mode;
    logic              locked_q;
    logic              pull_q;
    logic              wr_accept, wr_lock;
    logic              at_ack, at_end, load_rd;

    twi_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_wr_policy u_pol (
        .ptr       (ptr),
        .wel       (wel_i),
        .locked    (locked_q),
        .accept    (wr_accept),
        .lock_next (wr_lock)
    );

    always_comb begin
        at_ack  = scl_fall && (cnt == CNT_W'(ACK_SLOT));
        at_end  = scl_fall && (cnt == CNT_W'(END_SLOT));
        load_rd = at_end && (((phase == PH_DEV) && rd_mode) ||
                             ((phase == PH_RD) && !shreg[0]));
    end

    assign mem_addr_o  = ptr;
    assign mem_wdata_o = shreg;
    assign mem_we_o    = at_ack && (phase == PH_WR) && wr_accept
                         && !start_det && !stop_det;
    assign mem_re_o    = load_rd && !start_det && !stop_det;
    assign sda_pull_o  = pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txbuf    <= '0;
            ptr      <= '0;
            rd_mode  <= 1'b0;
            locked_q <= 1'b0;
            pull_q   <= 1'b0;
        end else if (start_det) begin
            phase    <= PH_DEV;
            cnt      <= '0;
            locked_q <= 1'b0;
            pull_q   <= 1'b0;
        end else if (stop_det) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            pull_q <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (scl_rise) begin
                shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                if (cnt != CNT_W'(END_SLOT)) cnt <= cnt + 1'b1;
            end
            if (at_ack) begin
                unique case (phase)
                    PH_DEV: begin
                        if (dev_match(shreg, strap_i)) begin
                            pull_q  <= 1'b1;
                            rd_mode <= shreg[0];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_PTR: begin
                        ptr    <= shreg;
                        pull_q <= 1'b1;
                    end
                    PH_WR: begin
                        if (wr_accept) begin
                            pull_q   <= 1'b1;
                            ptr      <= ptr + 1'b1;
                            locked_q <= wr_lock;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    default: pull_q <= 1'b0;   // read: hand bus to master
                endcase
            end else if (at_end) begin
                cnt <= '0;
                if (load_rd) begin
                    phase  <= PH_RD;
                    txbuf  <= mem_rdata_i;
                    ptr    <= ptr + 1'b1;
                    pull_q <= ~mem_rdata_i[BYTE_W-1];
                end else begin
                    pull_q <= 1'b0;
                    unique case (phase)
                        PH_DEV:  phase <= PH_PTR;
                        PH_PTR:  phase <= PH_WR;
                        PH_RD:   phase <= PH_IDLE;
                        default: phase <= phase;
                    endcase
                end
            end else if (scl_fall && (phase == PH_RD) && (cnt != '0)) begin
                txbuf  <= {txbuf[BYTE_W-2:0], 1'b0};
                pull_q <= ~txbuf[BYTE_W-2];
            end
        end
    end

    assert_start_rearm_R1: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (phase == PH_DEV) && !sda_pull_o);

    assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_pull_o);

    assert_we_gate_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (wel_i || (mem_addr_o == EXEMPT_ADDR)));

    assert_locked_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        locked_q |-> !mem_we_o);

    assert_no_rsvd_write_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !is_rsvd(mem_addr_o));

    assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_lvl));

endmodule

// File: tb/twi_wel_slave_tb.sv
`timescale 1ns/1ps
module twi_wel_slave_tb;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wel = 1'b0;
    logic sda_pull;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic mem_we, mem_re;
    logic [7:0] bmem [256];
    wire  sda_bus = m_sda & ~sda_pull;

    int n_checks = 0;
    int n_fail   = 0;
    int r12_viol = 0;
    bit done     = 1'b0;
    logic prev_pull = 1'b0;

    always #2.5 clk = ~clk;

    twi_wel_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_pull_o  (sda_pull),
        .strap_i     (STRAP),
        .wel_i       (wel),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .mem_rdata_i (mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr];

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'hC3;
    end

    always @(posedge clk) if (!rst && mem_we) bmem[mem_addr] <= mem_wdata;

    always @(negedge clk) begin
        if (!rst && scl && (sda_pull !== prev_pull)) r12_viol++;
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic m_bit(input logic b);
        m_sda = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        acked = (sda_bus == 1'b0);
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1'b1; wq(Q);
            b[i] = sda_bus;
            wq(Q); scl = 1'b0;
        end
        wq(Q);
        m_sda = give_ack ? 1'b0 : 1'b1;
        wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk(sda_pull == 1'b0, "R2 pull off after reset", sda_pull, 0);
        chk(mem_we == 1'b0, "R2 no write after reset", mem_we, 0);
    endtask

    task automatic t_no_start();
        bit a;
        scl = 1'b0; wq(Q);
        m_wbyte(DEVW, a);
        chk(a == 1'b0, "R2 no ack without START", a, 0);
        m_stop();
    endtask

    task automatic t_write();
        bit a;
        wel = 1'b1;
        m_start();
        m_wbyte(DEVW, a); chk(a, "R3 device byte acked", a, 1);
        m_wbyte(8'h10, a); chk(a, "R4 pointer byte acked", a, 1);
        m_wbyte(8'h5A, a); chk(a, "R5 data acked", a, 1);
        m_wbyte(8'h3C, a); chk(a, "R5 second data acked", a, 1);
        m_stop();
        chk(bmem[8'h10] == 8'h5A, "R5 write at pointer", bmem[8'h10], 8'h5A);
        chk(bmem[8'h11] == 8'h3C, "R5 pointer increment", bmem[8'h11], 8'h3C);
        chk(sda_pull == 1'b0, "R1 released after STOP", sda_pull, 0);
    endtask

    task automatic t_bad_addr();
        bit a;
        m_start();
        m_wbyte(8'hBA, a); chk(!a, "R3 wrong type no ack", a, 0);
        m_stop();
        m_start();
        m_wbyte({4'b1010, 3'b011, 1'b0}, a); chk(!a, "R3 wrong strap no ack", a, 0);
        m_stop();
    endtask

    task automatic t_wel_low();
        bit a;
        wel = 1'b0;
        m_start();
        m_wbyte(DEVW, a);
        m_wbyte(8'h20, a); chk(a, "R4 pointer acked with wel low", a, 1);
        m_wbyte(8'h77, a); chk(!a, "R6 data refused wel low", a, 0);
        m_wbyte(8'h55, a); chk(!a, "R10 silent after refusal", a, 0);
        m_stop();
        chk(bmem[8'h20] == (8'h20 ^ 8'hC3), "R6 no write wel low", bmem[8'h20], 8'h20 ^ 8'hC3);
        chk(bmem[8'h21] == (8'h21 ^ 8'hC3), "R10 no write after refusal", bmem[8'h21], 8'h21 ^ 8'hC3);
        m_start();
        m_wbyte(DEVW, a);
        m_wbyte(8'h86, a);
        m_wbyte(8'h12, a); chk(a, "R6 exempt 86h acked", a, 1);
        m_wbyte(8'h34, a); chk(!a, "R7 byte after 86h refused", a, 0);
        m_stop();
        chk(bmem[8'h86] == 8'h12, "R6 exempt 86h written", bmem[8'h86], 8'h12);
        chk(bmem[8'h87] == (8'h87 ^ 8'hC3), "R7 87h untouched", bmem[8'h87], 8'h87 ^ 8'hC3);
    endtask

    task automatic t_lock();
        bit a;
        wel = 1'b1;
        m_start();
        m_wbyte(DEVW, a);
        m_wbyte(8'h80, a);
        m_wbyte(8'h11, a); chk(a, "R7 80h write acked", a, 1);
        m_wbyte(8'h22, a); chk(!a, "R7 byte after 80h refused", a, 0);
        m_stop();
        chk(bmem[8'h80] == 8'h11, "R7 80h written", bmem[8'h80], 8'h11);
        chk(bmem[8'h81] == (8'h81 ^ 8'hC3), "R7 81h untouched", bmem[8'h81], 8'h81 ^ 8'hC3);
        m_start();
        m_wbyte(DEVW, a);
        m_wbyte(8'h85, a);
        m_wbyte(8'h44, a); chk(a, "R7 85h write acked", a, 1);
        m_wbyte(8'h45, a); chk(!a, "R7 byte after 85h refused", a, 0);
        m_stop();
    endtask

    task automatic t_reserved();
        bit a;
        wel = 1'b1;
        m_start();
        m_wbyte(DEVW, a);
        m_wbyte(8'h8A, a);
        m_wbyte(8'h99, a); chk(!a, "R8 reserved refused", a, 0);
        m_stop();
        chk(bmem[8'h8A] == (8'h8A ^ 8'hC3), "R8 reserved untouched", bmem[8'h8A], 8'h8A ^ 8'hC3);
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] b;
        m_start();
        m_wbyte(DEVW, a);
        m_wbyte(8'h10, a);
        m_start();
        m_wbyte(DEVR, a); chk(a, "R11 read device acked after repeated START", a, 1);
        m_rbyte(1'b1, b); chk(b == 8'h5A, "R9 first read byte", b, 8'h5A);
        m_rbyte(1'b0, b); chk(b == 8'h3C, "R9 auto-increment read", b, 8'h3C);
        chk(sda_pull == 1'b0, "R9 released after NACK", sda_pull, 0);
        m_stop();
    endtask

    task automatic t_abort();
        bit a;
        wel = 1'b1;
        m_start();
        for (int i = 7; i >= 4; i--) m_bit(DEVW[i]);
        m_start();
        m_wbyte(DEVW, a); chk(a, "R1 repeated START restarts address", a, 1);
        m_wbyte(8'h40, a);
        m_wbyte(8'h66, a);
        m_stop();
        chk(bmem[8'h40] == 8'h66, "R1 write after aborted byte", bmem[8'h40], 8'h66);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wq(4);
        t_reset();
        t_no_start();
        t_write();
        t_bad_addr();
        t_wel_low();
        t_lock();
        t_reserved();
        t_read();
        t_abort();
        chk(r12_viol == 0, "R12 pull changes only with SCL low", r12_viol, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule